// File: doc/BRIEF.md
# Pipelined Label Equivalence Table

This block records which provisional component labels belong together while a connected-component labeler streams a frame. Each clock the labeler may hand it one pair of labels found to touch. The block keeps a table of parent links: every entry starts out pointing at itself, and each pair causes the larger of the two current links to be pointed at the smaller one. Parents therefore always sit at smaller addresses than their children. A new pair is taken every cycle. A forward path covers the case where a pair reads an entry that the previous pair is still writing.

When the end of the frame is signalled, the block finishes the last merge and then scans the table upward from label 0. Each entry is replaced by the value its parent already holds. Because a parent is smaller than its child, it has been finalized earlier in the same scan, so one pass leaves every label pointing at the root of its group. A done flag then rises, and downstream logic reads the final label of any provisional label through a lookup port with one cycle of read latency. A frame-start strobe refills the table with identity links, one entry per cycle, before the next frame's pairs are accepted.

Top module: `label_equiv_table`

## Requirements
- R1: While reset is held, and for exactly DEPTH clock cycles after it is released, busy_o is 1 and done_o is 0 while the table is refilled. After that, busy_o and done_o are both 0 and pairs are accepted.
- R2: After a refill with no pairs merged, the lookup of every label returns the label itself.
- R3: An accepted pair (a, b) reads the current links la = T[a] and lb = T[b]. If la differs from lb, the entry at max(la, lb) is overwritten with min(la, lb). If they are equal, the table is left unchanged.
- R4: Pairs may arrive on consecutive cycles, including pairs that touch an entry written by the pair just before. The final table equals the one obtained by applying the pairs one at a time in arrival order.
- R5: A cycle with eof_i high while the block is accepting pairs starts resolution. busy_o is 1 for exactly 2*DEPTH+2 cycles, after which done_o is 1.
- R6: Resolution visits labels in ascending order and sets T[i] = T[T[i]]. When done_o is 1, lookup_label_o shows, one cycle after lookup_addr_i is presented, the resolved entry for that address.
- R7: pair_valid_i and eof_i have no effect while busy_o or done_o is 1. frame_start_i has no effect while busy_o is 1.
- R8: frame_start_i while accepting pairs or while done_o is 1 drops done_o and starts a refill of DEPTH cycles. A pair presented in that same cycle is dropped.
- R9: A pair presented in the same cycle as eof_i is merged before resolution begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Strobe: refill the table with identity links |
| pair_valid_i | input | 1 | Strobe: pair_a_i and pair_b_i are equivalent |
| pair_a_i | input | LW | First label of the pair |
| pair_b_i | input | LW | Second label of the pair |
| eof_i | input | 1 | Strobe: last pair of the frame has been presented |
| lookup_addr_i | input | LW | Provisional label to look up |
| busy_o | output | 1 | Table is being refilled or resolved |
| done_o | output | 1 | Resolution finished; lookups are valid |
| lookup_label_o | output | LW | Resolved label, one cycle after lookup_addr_i |

## Verification
A wrong parent link stays hidden during the frame. It only appears once resolution ends, as a wrong label on lookup_label_o for that entry and for every label chained below it. For this reason each merging frame is followed by a full sweep of all labels. A missing or misdirected forward of an in-flight write only corrupts the table when two dependent pairs come back to back, so bursts of chained pairs on consecutive cycles are driven. Sequencing faults show at once: busy_o and done_o are compared with a cycle-counting model on every clock, so an off-by-one in the refill or scan length is caught in the cycle it happens.

// File: rtl/leq_pkg.sv
package leq_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_RUN,
    ST_FLUSH,
    ST_RESOLVE,
    ST_LAST,
    ST_DONE
  } leq_state_e;
endpackage

// File: rtl/leq_mem.sv
// Two read ports, one write port, registered reads, write-to-read forwarding.
module leq_mem #(
  parameter int DEPTH     = 1024,
  parameter int AW        = $clog2(DEPTH),
  parameter bit TWO_BANKS = 1'b1
) (
  input  logic          clk_i,
  input  logic [AW-1:0] ra_addr_i,
  input  logic [AW-1:0] rb_addr_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] ra_data_o,
  output logic [AW-1:0] rb_data_o
);
  logic fwd_a, fwd_b;
  assign fwd_a = we_i && (waddr_i == ra_addr_i);
  assign fwd_b = we_i && (waddr_i == rb_addr_i);

  generate
    if (TWO_BANKS) begin : g_banked
      // two copies written together, each feeding one read port
      logic [AW-1:0] bank_a [DEPTH];
      logic [AW-1:0] bank_b [DEPTH];
      always_ff @(posedge clk_i) begin
        if (we_i) begin
          bank_a[waddr_i] <= wdata_i;
          bank_b[waddr_i] <= wdata_i;
        end
        ra_data_o <= fwd_a ? wdata_i : bank_a[ra_addr_i];
        rb_data_o <= fwd_b ? wdata_i : bank_b[rb_addr_i];
      end
    end else begin : g_single
      logic [AW-1:0] cells [DEPTH];
      always_ff @(posedge clk_i) begin
        if (we_i) cells[waddr_i] <= wdata_i;
        ra_data_o <= fwd_a ? wdata_i : cells[ra_addr_i];
        rb_data_o <= fwd_b ? wdata_i : cells[rb_addr_i];
      end
    end
  endgenerate
endmodule

// File: rtl/leq_merge.sv
// Second merge stage: point the larger fetched link at the smaller one.
module leq_merge #(
  parameter int LW = 10
) (
  input  logic          valid_i,
  input  logic [LW-1:0] link_a_i,
  input  logic [LW-1:0] link_b_i,
  output logic          req_o,
  output logic [LW-1:0] child_o,
  output logic [LW-1:0] parent_o
);
  logic a_hi;
  assign a_hi     = link_a_i > link_b_i;
  assign child_o  = a_hi ? link_a_i : link_b_i;
  assign parent_o = a_hi ? link_b_i : link_a_i;
  assign req_o    = valid_i && (link_a_i != link_b_i);
endmodule

// File: rtl/label_equiv_table.sv
module label_equiv_table
  import leq_pkg::*;
#(
  parameter int DEPTH     = 1024,
  parameter int LW        = $clog2(DEPTH),
  parameter bit TWO_BANKS = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  input  logic          pair_valid_i,
  input  logic [LW-1:0] pair_a_i,
  input  logic [LW-1:0] pair_b_i,
  input  logic          eof_i,
  input  logic [LW-1:0] lookup_addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [LW-1:0] lookup_label_o
);
  localparam logic [LW-1:0] LAST_IDX = LW'(DEPTH - 1);

  leq_state_e    state_q;
  logic [LW-1:0] idx_q;
  logic          ph_q;
  logic          m_v_q;

  logic          accept;
  logic [LW-1:0] ra_addr, rb_addr, rd_a, rd_b;
  logic          we;
  logic [LW-1:0] waddr, wdata;
  logic          mg_req;
  logic [LW-1:0] mg_child, mg_parent;

  assign accept = (state_q == ST_RUN) && pair_valid_i && !frame_start_i;

  leq_mem #(.DEPTH(DEPTH), .AW(LW), .TWO_BANKS(TWO_BANKS)) i_mem (
    .clk_i    (clk_i),
    .ra_addr_i(ra_addr),
    .rb_addr_i(rb_addr),
    .we_i     (we),
    .waddr_i  (waddr),
    .wdata_i  (wdata),
    .ra_data_o(rd_a),
    .rb_data_o(rd_b)
  );

  leq_merge #(.LW(LW)) i_merge (
    .valid_i (m_v_q),
    .link_a_i(rd_a),
    .link_b_i(rd_b),
    .req_o   (mg_req),
    .child_o (mg_child),
    .parent_o(mg_parent)
  );

  // read port steering
  always_comb begin
    ra_addr = pair_a_i;
    rb_addr = pair_b_i;
    unique case (state_q)
      ST_RESOLVE: begin
        ra_addr = idx_q;
        rb_addr = rd_a;  // parent fetched in the previous phase
      end
      ST_DONE: ra_addr = lookup_addr_i;
      default: ;
    endcase
  end

  // write port steering
  always_comb begin
    we    = 1'b0;
    waddr = idx_q;
    wdata = idx_q;
    unique case (state_q)
      ST_CLEAR: we = 1'b1;
      ST_RUN, ST_FLUSH: begin
        we    = mg_req;
        waddr = mg_child;
        wdata = mg_parent;
      end
      ST_RESOLVE: begin
        // commit the previous entry while the next one is fetched
        we    = !ph_q && (idx_q != '0);
        waddr = idx_q - LW'(1);
        wdata = rd_b;
      end
      ST_LAST: begin
        we    = 1'b1;
        waddr = LAST_IDX;
        wdata = rd_b;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CLEAR;
      idx_q   <= '0;
      ph_q    <= 1'b0;
      m_v_q   <= 1'b0;
    end else begin
      m_v_q <= accept;
      unique case (state_q)
        ST_CLEAR: begin
          if (idx_q == LAST_IDX) begin
            state_q <= ST_RUN;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + LW'(1);
          end
        end
        ST_RUN: begin
          if (frame_start_i) begin
            state_q <= ST_CLEAR;
            idx_q   <= '0;
          end else if (eof_i) begin
            state_q <= ST_FLUSH;
          end
        end
        ST_FLUSH: begin
          state_q <= ST_RESOLVE;
          idx_q   <= '0;
          ph_q    <= 1'b0;
        end
        ST_RESOLVE: begin
          ph_q <= !ph_q;
          if (ph_q) begin
            if (idx_q == LAST_IDX) state_q <= ST_LAST;
            else idx_q <= idx_q + LW'(1);
          end
        end
        ST_LAST: state_q <= ST_DONE;
        ST_DONE: begin
          if (frame_start_i) begin
            state_q <= ST_CLEAR;
            idx_q   <= '0;
          end
        end
        default: state_q <= ST_CLEAR;
      endcase
    end
  end

  assign busy_o         = (state_q == ST_CLEAR) || (state_q == ST_FLUSH) ||
                          (state_q == ST_RESOLVE) || (state_q == ST_LAST);
  assign done_o         = (state_q == ST_DONE);
  assign lookup_label_o = rd_a;

  AST_CLEAR_IDENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CLEAR) |-> (we && wdata == waddr)); // R2
  AST_LINK_DOWNWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && state_q != ST_CLEAR) |-> (wdata < waddr || wdata == waddr)); // R3
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o)); // R5
  AST_DONE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !we); // R6
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !frame_start_i) |=> done_o); // R8
  AST_BUSY_NO_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && pair_valid_i) |=> !m_v_q); // R7
endmodule

// File: tb/test_label_equiv_table.sv
module test_label_equiv_table;
  localparam int DEPTH = 1024;
  localparam int LW    = 10;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  localparam int M_CLR  = 0;
  localparam int M_RUN  = 1;
  localparam int M_RES  = 2;
  localparam int M_DONE = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          frame_start_i = 1'b0;
  logic          pair_valid_i = 1'b0;
  logic [LW-1:0] pair_a_i = '0;
  logic [LW-1:0] pair_b_i = '0;
  logic          eof_i = 1'b0;
  logic [LW-1:0] lookup_addr_i = '0;
  logic          busy_o, done_o;
  logic [LW-1:0] lookup_label_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  label_equiv_table #(.DEPTH(DEPTH), .LW(LW)) i_label_equiv_table (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .pair_valid_i  (pair_valid_i),
    .pair_a_i      (pair_a_i),
    .pair_b_i      (pair_b_i),
    .eof_i         (eof_i),
    .lookup_addr_i (lookup_addr_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .lookup_label_o(lookup_label_o)
  );

  int vectors = 0;
  int fails   = 0;
  int mode    = M_CLR;
  int cnt     = 0;
  int tbl [DEPTH];
  bit lk_chk  = 1'b0;
  int lk_exp  = 0;
  string cur_req = "R1";
  int unsigned lcg = 32'h1234_5678;

  task automatic ident();
    for (int i = 0; i < DEPTH; i++) tbl[i] = i;
  endtask

  task automatic model_edge();
    int la, lb;
    lk_chk = (mode == M_DONE);
    lk_exp = tbl[lookup_addr_i];
    case (mode)
      M_CLR: begin
        cnt++;
        if (cnt == DEPTH) mode = M_RUN;
      end
      M_RUN: begin
        if (frame_start_i) begin
          mode = M_CLR; cnt = 0; ident();
        end else begin
          if (pair_valid_i) begin
            la = tbl[pair_a_i];
            lb = tbl[pair_b_i];
            if (la > lb) tbl[la] = lb;
            else if (lb > la) tbl[lb] = la;
          end
          if (eof_i) begin
            mode = M_RES; cnt = 0;
          end
        end
      end
      M_RES: begin
        cnt++;
        if (cnt == 2*DEPTH + 2) begin
          for (int i = 0; i < DEPTH; i++) tbl[i] = tbl[tbl[i]];
          mode = M_DONE;
        end
      end
      default: begin
        if (frame_start_i) begin
          mode = M_CLR; cnt = 0; ident();
        end
      end
    endcase
  endtask

  task automatic compare();
    bit eb, ed;
    string tag;
    eb = (mode == M_CLR) || (mode == M_RES);
    ed = (mode == M_DONE);
    case (mode)
      M_CLR:   tag = "R1";
      M_RES:   tag = "R5";
      M_RUN:   tag = "R7";
      default: tag = "R8";
    endcase
    vectors++;
    if (busy_o !== eb || done_o !== ed) begin
      fails++;
      $display("FAIL %s busy/done=%0b%0b expected %0b%0b", tag, busy_o, done_o, eb, ed);
    end
    if (lk_chk) begin
      vectors++;
      if (lookup_label_o !== LW'(lk_exp)) begin
        fails++;
        $display("FAIL %s R6 lookup=%0d expected %0d", cur_req, lookup_label_o, lk_exp);
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic send(input int a, input int b, input bit last);
    pair_valid_i = 1'b1;
    pair_a_i = LW'(a);
    pair_b_i = LW'(b);
    eof_i = last;
    cyc();
    pair_valid_i = 1'b0;
    eof_i = 1'b0;
  endtask

  task automatic end_frame();
    eof_i = 1'b1;
    cyc();
    eof_i = 1'b0;
  endtask

  task automatic start_frame();
    frame_start_i = 1'b1;
    cyc();
    frame_start_i = 1'b0;
  endtask

  task automatic wait_mode(input int m);
    while (mode != m) cyc();
  endtask

  task automatic sweep();
    for (int i = 0; i < DEPTH; i++) begin
      lookup_addr_i = LW'(i);
      cyc();
    end
  endtask

  function automatic int rnd(input int lo, input int span);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lo + int'((lcg >> 16) % span);
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog expired after %0d cycles expected completion", WATCHDOG);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    ident();
    repeat (3) @(negedge clk);
    // R1: reset state
    vectors++;
    if (busy_o !== 1'b1 || done_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset busy/done=%0b%0b expected 10", busy_o, done_o);
    end
    rst_ni = 1'b1;
    // R1: refill length, checked each cycle
    wait_mode(M_RUN);
    idle(2);

    // R2: frame with no pairs resolves to identity
    cur_req = "R2";
    end_frame();
    wait_mode(M_DONE);
    sweep();

    // R8: new frame from done
    cur_req = "R8";
    start_frame();
    wait_mode(M_RUN);

    // R3: isolated pairs, both orders, equal links
    cur_req = "R3";
    send(5, 3, 0);  idle(2);
    send(7, 5, 0);  idle(2);
    send(9, 9, 0);  idle(2);
    send(12, 20, 0); idle(2);
    send(20, 15, 0); idle(2);
    send(3, 7, 0);  idle(2);

    // R4: back-to-back dependent pairs
    cur_req = "R4";
    send(30, 31, 0);
    send(31, 32, 0);
    send(32, 29, 0);
    send(29, 28, 0);
    send(28, 33, 0);
    send(40, 41, 0);
    send(41, 40, 0);
    for (int k = 0; k < 60; k++) send(rnd(40, 50), rnd(40, 50), 0);
    for (int k = 0; k < 40; k++) send(rnd(100, 900), rnd(100, 900), 0);
    send(1023, 1000, 0);
    send(1000, 999, 0);
    idle(1);

    // R9: pair on the eof cycle
    cur_req = "R9";
    send(200, 150, 1);

    // R7: pairs, eof and frame_start ignored while resolving
    cur_req = "R7";
    idle(3);
    send(150, 2, 0);
    send(2, 1, 1);
    start_frame();
    idle(10);
    send(600, 4, 0);
    wait_mode(M_DONE);

    cur_req = "R6";
    sweep();

    // R7: pairs and eof in done have no effect
    cur_req = "R7";
    send(50, 1, 0);
    send(1, 0, 1);
    idle(2);
    sweep();

    // R8: restart mid-frame discards merges and drops same-cycle pair
    cur_req = "R8";
    start_frame();
    wait_mode(M_RUN);
    send(10, 2, 0);
    send(11, 10, 0);
    pair_valid_i = 1'b1; pair_a_i = LW'(20); pair_b_i = LW'(1);
    frame_start_i = 1'b1;
    cyc();
    pair_valid_i = 1'b0; frame_start_i = 1'b0;
    wait_mode(M_RUN);
    send(3, 1, 0);
    send(6, 3, 1);
    wait_mode(M_DONE);
    sweep();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule